// File: doc/BRIEF.md
# Masked Vectored Interrupt Controller

This block gathers interrupt requests for a 68000-style processor from six sources: three external request lines and three timer expiry pulses. Each source owns a pending flag. An external line sets its flag on a rising edge, and a timer sets its flag on any cycle its pulse is high. A source competes for the processor only when three things hold: its flag is set, its mask bit is clear, and its programmed priority level is non-zero. The winner's level is driven on the 3-bit priority output.

When the processor runs an acknowledge cycle it pulses `iack`. The controller presents an 8-bit vector number during that cycle and clears the winner's pending flag at the same clock edge. The vector number is the top three bits of a software-written base register followed by the 5-bit index of the winning source. Software programs levels, masks and the base through a 16-bit register port. That port is addressed by byte offset, writes in one cycle, and reads combinationally.

Top module: `mvic_top`

## Requirements
- R1: After reset, no flag is pending and `ipl` is 0. Every mask bit is set, so reading offset 0x94 returns 0x0707. Every level register reads 0 and the base register reads 0.
- R2: A 0-to-1 transition on `ext_irq[i]` sets the pending flag of source i on the next clock edge. A line held high does not set the flag again after it has been acknowledged. It must return low and rise again.
- R3: On every clock edge where `tmr_pulse[j]` is high, the pending flag of source 3+j is set.
- R4: The mask register is at offset 0x94. Bit i masks external source i, and bit 8+j masks timer source 3+j. A masked source never drives `ipl`, but its pending flag is kept and the source competes again once it is unmasked.
- R5: The level registers are at offsets 0x88, 0x8A and 0x8C for external sources 0..2, and at 0x8E, 0x90 and 0x92 for timer sources 0..2. Bits 2:0 hold the level. Level 0 keeps the source out of arbitration without clearing its flag.
- R6: `ipl` equals the highest level among eligible sources, or 0 if no source is eligible. It is combinational from the stored state, so it changes right after the edge that sets a flag.
- R7: When eligible sources have equal levels, the one with the lower index wins. The indices are external 0..2 = 0..2 and timer 0..2 = 3..5.
- R8: The base register is at offset 0x9A and stores bits 7:0. While `ipl` is non-zero, `iack_vec` is {base[7:5], 5-bit winner index}. Otherwise `iack_vec` is 0.
- R9: A clock edge with `iack` high clears only the winner's pending flag. An acknowledge while `ipl` is 0 changes nothing, and neither does an acknowledge that finds a pending source masked.
- R10: If a new event for the winning source arrives in the same cycle as its acknowledge, the pending flag stays set.
- R11: Reads of unmapped offsets return 0, and writes to them have no effect. Register bits that are not stored read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq | input | 3 | External request lines, rising-edge latched |
| tmr_pulse | input | 3 | Timer expiry pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| ipl | output | 3 | Priority level presented to the processor |
| iack | input | 1 | Acknowledge pulse |
| iack_vec | output | 8 | Vector number of the current winner |

## Verification
The bench targets several corner cases, each of which a faulty design would get visibly wrong:
- Equal-level ties: a design with reversed priority would answer with the higher index.
- Masked or level-0 sources: a design that discards the pending flag instead of gating it would never raise `ipl` after the source is unmasked.
- An external line held high after its acknowledge: a design that latches the level rather than the edge would raise the same interrupt again at once.
- An event that coincides with its own acknowledge: a design that lets the clear win would lose that event.
- An acknowledge while the only pending source is masked: a design that clears without checking the winner would lose that source's request.
- Register read-back with all bits written as ones: a design that decodes offsets or fields wrongly would expose stray bits.

// File: rtl/mvic_pkg.sv
package mvic_pkg;
    localparam int ADDR_W       = 8;
    localparam int DATA_W       = 16;
    localparam int LVL_W        = 3;
    localparam int IDX_W        = 5;
    localparam int VEC_W        = 8;
    localparam int OFF_LVL0     = 'h88;
    localparam int OFF_MASK     = 'h94;
    localparam int OFF_BASE     = 'h9A;
    localparam int TMR_MASK_LSB = 8;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        logic             valid;
        lvl_t             lvl;
        logic [IDX_W-1:0] idx;
    } win_t;

    function automatic logic [VEC_W-1:0] make_vec(input logic [VEC_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
        return {base[VEC_W-1:IDX_W], idx};
    endfunction
endpackage

// File: rtl/mvic_regs.sv
module mvic_regs
    import mvic_pkg::*;
#(
    parameter int N_EXT = 3,
    parameter int N_TMR = 3,
    localparam int N_SRC = N_EXT + N_TMR
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output logic [N_SRC-1:0]             src_mask,
    output logic [N_SRC-1:0][LVL_W-1:0]  src_lvl,
    output logic [VEC_W-1:0]             base
);
    logic [N_SRC-1:0][LVL_W-1:0] lvl_q;
    logic [N_EXT-1:0]            mask_ext_q;
    logic [N_TMR-1:0]            mask_tmr_q;
    logic [VEC_W-1:0]            base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q      <= '0;
            mask_ext_q <= '1;
            mask_tmr_q <= '1;
            base_q     <= '0;
        end else if (we) begin
            for (int i = 0; i < N_SRC; i++) begin
                if (addr == ADDR_W'(OFF_LVL0 + 2 * i)) lvl_q[i] <= wdata[LVL_W-1:0];
            end
            if (addr == ADDR_W'(OFF_MASK)) begin
                mask_ext_q <= wdata[N_EXT-1:0];
                mask_tmr_q <= wdata[TMR_MASK_LSB +: N_TMR];
            end
            if (addr == ADDR_W'(OFF_BASE)) base_q <= wdata[VEC_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (addr == ADDR_W'(OFF_LVL0 + 2 * i)) rdata[LVL_W-1:0] = lvl_q[i];
        end
        if (addr == ADDR_W'(OFF_MASK)) begin
            rdata[N_EXT-1:0]            = mask_ext_q;
            rdata[TMR_MASK_LSB +: N_TMR] = mask_tmr_q;
        end
        if (addr == ADDR_W'(OFF_BASE)) rdata[VEC_W-1:0] = base_q;
    end

    assign src_mask = {mask_tmr_q, mask_ext_q};
    assign src_lvl  = lvl_q;
    assign base     = base_q;

    // R1: reset leaves every source masked
    p_reset_masked_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&src_mask));

    // R4: a mask write lands in the proper bit positions
    p_mask_write_r4: assert property (@(posedge clk) disable iff (rst)
        (we && addr == ADDR_W'(OFF_MASK)) |=>
        (src_mask == {$past(wdata[TMR_MASK_LSB +: N_TMR]), $past(wdata[N_EXT-1:0])}));
endmodule

// File: rtl/mvic_pend.sv
module mvic_pend
    import mvic_pkg::*;
#(
    parameter int N_EXT = 3,
    parameter int N_TMR = 3,
    localparam int N_SRC = N_EXT + N_TMR
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_EXT-1:0] ext_irq,
    input  logic [N_TMR-1:0] tmr_pulse,
    input  logic [N_SRC-1:0] ack_clr,
    output logic [N_SRC-1:0] pend
);
    logic [N_EXT-1:0] ext_prev;
    logic [N_SRC-1:0] set_ev;

    assign set_ev = {tmr_pulse, ext_irq & ~ext_prev};

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_prev <= '0;
            pend     <= '0;
        end else begin
            ext_prev <= ext_irq;
            pend     <= (pend & ~ack_clr) | set_ev;
        end
    end

    generate
        for (genvar i = 0; i < N_EXT; i++) begin : g_ext_chk
            // R2: a rising line is latched
            p_ext_latch_r2: assert property (@(posedge clk) disable iff (rst)
                $rose(ext_irq[i]) |=> pend[i]);
        end
        for (genvar j = 0; j < N_TMR; j++) begin : g_tmr_chk
            // R3: a timer pulse is latched
            p_tmr_latch_r3: assert property (@(posedge clk) disable iff (rst)
                tmr_pulse[j] |=> pend[N_EXT + j]);
        end
        for (genvar k = 0; k < N_SRC; k++) begin : g_ack_chk
            // R9: an acknowledged flag clears when no new event arrives
            p_ack_clears_r9: assert property (@(posedge clk) disable iff (rst)
                (ack_clr[k] && !set_ev[k]) |=> !pend[k]);
            // R10: a coinciding event keeps the flag set
            p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
                (ack_clr[k] && set_ev[k]) |=> pend[k]);
        end
    endgenerate
endmodule

// File: rtl/mvic_arb.sv
module mvic_arb
    import mvic_pkg::*;
#(
    parameter int N_SRC = 6
) (
    input  logic [N_SRC-1:0]            pend,
    input  logic [N_SRC-1:0]            src_mask,
    input  logic [N_SRC-1:0][LVL_W-1:0] src_lvl,
    output win_t                        win
);
    always_comb begin
        win = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (pend[i] && !src_mask[i] && (src_lvl[i] > win.lvl)) begin
                win.valid = 1'b1;
                win.lvl   = src_lvl[i];
                win.idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/mvic_top.sv
module mvic_top
    import mvic_pkg::*;
#(
    parameter int N_EXT = 3,
    parameter int N_TMR = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_EXT-1:0]  ext_irq,
    input  logic [N_TMR-1:0]  tmr_pulse,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [LVL_W-1:0]  ipl,
    input  logic              iack,
    output logic [VEC_W-1:0]  iack_vec
);
    localparam int N_SRC = N_EXT + N_TMR;

    logic [N_SRC-1:0]            src_mask;
    logic [N_SRC-1:0][LVL_W-1:0] src_lvl;
    logic [VEC_W-1:0]            base;
    logic [N_SRC-1:0]            pend;
    logic [N_SRC-1:0]            ack_clr;
    win_t                        win;

    mvic_regs #(.N_EXT(N_EXT), .N_TMR(N_TMR)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .src_mask(src_mask), .src_lvl(src_lvl), .base(base)
    );

    mvic_pend #(.N_EXT(N_EXT), .N_TMR(N_TMR)) u_pend (
        .clk(clk), .rst(rst), .ext_irq(ext_irq), .tmr_pulse(tmr_pulse),
        .ack_clr(ack_clr), .pend(pend)
    );

    mvic_arb #(.N_SRC(N_SRC)) u_arb (
        .pend(pend), .src_mask(src_mask), .src_lvl(src_lvl), .win(win)
    );

    always_comb begin
        for (int i = 0; i < N_SRC; i++) begin
            ack_clr[i] = iack && win.valid && (win.idx == IDX_W'(i));
        end
    end

    assign ipl      = win.lvl;
    assign iack_vec = win.valid ? make_vec(base, win.idx) : '0;

    // R6: with nothing pending the level output is idle
    p_idle_ipl_r6: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |-> (ipl == '0));

    // R8: the vector carries the base register's upper bits while requesting
    p_vec_base_r8: assert property (@(posedge clk) disable iff (rst)
        (ipl != '0) |-> (iack_vec[VEC_W-1:IDX_W] == base[VEC_W-1:IDX_W]));

    // R9: only one flag is cleared per acknowledge
    p_one_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_clr));
endmodule

// File: tb/mvic_top_tb.sv
module mvic_top_tb;
    typedef struct packed {
        logic [15:0] mask;
        logic [5:0]  pend;
        logic [17:0] lvls;
        logic [7:0]  base;
        logic [2:0]  exp_ipl;
        logic [7:0]  exp_vec;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{16'h0000, 6'h3F, 18'o654321, 8'hE0, 3'd6, 8'hE5},
        '{16'h0000, 6'h07, 18'o654321, 8'h5F, 3'd3, 8'h42},
        '{16'h0000, 6'h2A, 18'o444444, 8'hA0, 3'd4, 8'hA1},
        '{16'h0400, 6'h3F, 18'o654321, 8'h20, 3'd5, 8'h24},
        '{16'h0000, 6'h20, 18'o022222, 8'h00, 3'd0, 8'h00},
        '{16'h0707, 6'h3F, 18'o654321, 8'hFF, 3'd0, 8'h00},
        '{16'h0000, 6'h18, 18'o077000, 8'hC0, 3'd7, 8'hC3},
        '{16'h0003, 6'h07, 18'o000777, 8'h60, 3'd7, 8'h62}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  ext_irq = '0;
    logic [2:0]  tmr_pulse = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [2:0]  ipl;
    logic        iack = 1'b0;
    logic [7:0]  iack_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mvic_top u_dut (
        .clk(clk), .rst(rst), .ext_irq(ext_irq), .tmr_pulse(tmr_pulse),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ipl(ipl), .iack(iack), .iack_vec(iack_vec)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ext_irq = '0; tmr_pulse = '0; iack = 1'b0; reg_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic fire(input logic [2:0] e, input logic [2:0] t);
        ext_irq = e; tmr_pulse = t;
        @(negedge clk);
        tmr_pulse = '0;
    endtask

    task automatic ack();
        iack = 1'b1;
        @(negedge clk);
        iack = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        if (!done) begin
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // Table: R5 R6 R7 R8 R4 under several pending patterns
        for (int n = 0; n < NV; n++) begin
            do_reset();
            for (int i = 0; i < 6; i++) wr(8'(8'h88 + 2 * i), {13'd0, TBL[n].lvls[3*i +: 3]});
            wr(8'h94, TBL[n].mask);
            wr(8'h9A, {8'd0, TBL[n].base});
            fire(TBL[n].pend[2:0], TBL[n].pend[5:3]);
            ext_irq = '0;
            check($sformatf("R6 R7 ipl vec%0d", n), {13'd0, ipl}, {13'd0, TBL[n].exp_ipl});
            check($sformatf("R8 R7 vector vec%0d", n), {8'd0, iack_vec}, {8'd0, TBL[n].exp_vec});
        end

        // R1 reset state and R11 unmapped reads
        do_reset();
        check("R1 ipl after reset", {13'd0, ipl}, 16'h0000);
        check("R1 vector after reset", {8'd0, iack_vec}, 16'h0000);
        rd_chk("R1 mask after reset", 8'h94, 16'h0707);
        rd_chk("R1 level after reset", 8'h8E, 16'h0000);
        rd_chk("R1 base after reset", 8'h9A, 16'h0000);
        rd_chk("R11 unmapped read", 8'h00, 16'h0000);
        @(negedge clk);
        wr(8'h9A, 16'hFFFF);
        rd_chk("R8 base readback", 8'h9A, 16'h00FF);
        wr(8'h94, 16'hFFFF);
        rd_chk("R11 mask unused bits", 8'h94, 16'h0707);
        wr(8'h8A, 16'hFFFF);
        rd_chk("R11 level unused bits", 8'h8A, 16'h0007);
        wr(8'h96, 16'hFFFF);
        rd_chk("R11 write to unmapped", 8'h96, 16'h0000);

        // R4 masked flag kept
        do_reset();
        wr(8'h88, 16'd5);
        fire(3'b001, 3'b000);
        check("R4 masked source silent", {13'd0, ipl}, 16'd0);
        wr(8'h94, 16'h0000);
        check("R4 unmask restores request", {13'd0, ipl}, 16'd5);

        // R5 level zero keeps flag
        do_reset();
        wr(8'h94, 16'h0000);
        wr(8'h90, 16'd0);
        fire(3'b000, 3'b010);
        check("R5 level zero silent", {13'd0, ipl}, 16'd0);
        wr(8'h90, 16'd3);
        check("R5 level restored", {13'd0, ipl}, 16'd3);
        check("R3 R8 timer1 vector", {8'd0, iack_vec}, 16'h0004);

        // R2 R9 edge latch and acknowledge order
        do_reset();
        wr(8'h94, 16'h0000);
        wr(8'h88, 16'd2);
        wr(8'h8A, 16'd6);
        fire(3'b011, 3'b000);
        check("R6 higher level wins", {13'd0, ipl}, 16'd6);
        check("R8 vector ext1", {8'd0, iack_vec}, 16'h0001);
        ack();
        check("R9 other source remains", {13'd0, ipl}, 16'd2);
        ack();
        check("R9 all cleared", {13'd0, ipl}, 16'd0);
        repeat (3) @(negedge clk);
        check("R2 held line no relatch", {13'd0, ipl}, 16'd0);
        ext_irq = '0;
        @(negedge clk);
        fire(3'b001, 3'b000);
        check("R2 new edge latches", {13'd0, ipl}, 16'd2);

        // R9 idle and masked acknowledge; R10 coinciding event
        do_reset();
        wr(8'h94, 16'h0000);
        wr(8'h8E, 16'd4);
        ack();
        fire(3'b000, 3'b001);
        check("R3 timer0 latched", {13'd0, ipl}, 16'd4);
        wr(8'h94, 16'h0100);
        check("R4 timer mask bit8", {13'd0, ipl}, 16'd0);
        ack();
        wr(8'h94, 16'h0000);
        check("R9 masked ack kept flag", {13'd0, ipl}, 16'd4);
        iack = 1'b1;
        fire(3'b000, 3'b001);
        iack = 1'b0;
        check("R10 event beats ack", {13'd0, ipl}, 16'd4);
        ack();
        check("R9 ack clears timer0", {13'd0, ipl}, 16'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule